// File: doc/BRIEF.md
# Square-Wave Timer and Servo Pulse Generator

This peripheral sits beside a small logic-controller core and supplies two time bases that the core switches on and off. The first is a square-wave timer: a power-of-two prescaler feeds a counter that flips a level every 183 prescaled ticks. The result is a 50% duty wave with a 366-tick period. It leaves the block as a true and a complementary output, with one clock of dead time at each edge. The second is a servo pulse generator that repeats a frame of 235 units, about 20 ms. The pulse at the start of each frame lasts either a fixed 11 units or a programmable count, and one value bit picks which.

The core writes the 4-bit prescale exponent and the 5-bit programmable pulse count through one-cycle write strobes. Each enable freezes its counter when clear. The outputs then hold their last level, so the core can still read them. Width choices are taken up only at a frame boundary, so a pulse in flight is never cut short or stretched.

Top module: `timer_servo_pulse`

## Requirements
- R1: After reset, tmr_out is 0, tmr_out_n is 1 and srv_out is 0.
- R2: One prescaled tick occurs every 2^N clocks, where N is the stored exponent (N = 0 gives one tick per clock). tmr_out is high for 183 ticks minus one clock, and its rising edges are 366 ticks apart.
- R3: tmr_out and tmr_out_n are never high together. At every timer transition, both outputs are low for exactly one clock before the newly active output rises.
- R4: The stored exponent loads from div_val when div_wr is high and resets to 14. With the default exponent, tmr_out does not toggle within the first 20,000 enabled clocks.
- R5: While tmr_en is low, the timer counters hold and tmr_out and tmr_out_n keep their levels.
- R6: One servo unit is UNIT_CLKS clocks. Rising edges of srv_out are 235 units apart.
- R7: With srv_val = 0, the servo pulse is high for exactly 11 units.
- R8: With srv_val = 1, the pulse is high for the stored set count of units, from 0 to 31, where 0 gives no pulse. The set count loads from set_val when set_wr is high and resets to 23.
- R9: A change of srv_val or of the set count during a frame does not alter that frame's pulse. It applies from the next frame on.
- R10: While srv_en is low, the servo counters hold and srv_out keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_en | input | 1 | Timer count enable |
| div_wr | input | 1 | Load strobe for the prescale exponent |
| div_val | input | DIV_W | New prescale exponent N (divide by 2^N) |
| srv_en | input | 1 | Servo count enable |
| srv_val | input | 1 | Pulse select: 0 gives the fixed width, 1 gives the set count |
| set_wr | input | 1 | Load strobe for the set count |
| set_val | input | SET_W | New programmable pulse width in units |
| tmr_out | output | 1 | Timer output, 50% duty, with dead time |
| tmr_out_n | output | 1 | Complementary timer output, with dead time |
| srv_out | output | 1 | Servo pulse output |

## Verification
A wrong half-period count or a wrong prescale mask shows as a wrong high time or a wrong edge-to-edge distance within one timer period. The bench measures these in clocks for exponents 0 and 2. A broken dead-time stage shows at the first edge, either as overlap or as a missing low clock on both outputs. A servo width latched at the wrong moment shows within one or two frames: the pulse in flight is cut short or stretched, or the next pulse keeps the old width. The bench provokes this by changing the value bit and the set count halfway through a pulse.

// File: rtl/timer_servo_pulse.sv
module timer_servo_pulse #(
  parameter int DIV_W       = 4,
  parameter int DIV_INIT    = 14,
  parameter int TMR_PERIOD  = 366,
  parameter int SET_W       = 5,
  parameter int SET_INIT    = 23,
  parameter int FIX_WIDTH   = 11,
  parameter int FRAME_UNITS = 235,
  parameter int UNIT_CLKS   = 1021
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tmr_en,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_val,
  input  logic             srv_en,
  input  logic             srv_val,
  input  logic             set_wr,
  input  logic [SET_W-1:0] set_val,
  output logic             tmr_out,
  output logic             tmr_out_n,
  output logic             srv_out
);

  localparam int PC_W    = (2 ** DIV_W) - 1;
  localparam int HALF    = TMR_PERIOD / 2;
  localparam int HALF_W  = $clog2(HALF);
  localparam int FRAME_W = $clog2(FRAME_UNITS);
  localparam int UNIT_W  = $clog2(UNIT_CLKS + 1);

  // ---------------- square-wave timer ----------------
  logic [DIV_W-1:0]  div_q;
  logic [PC_W-1:0]   pre_cnt;
  logic [PC_W-1:0]   pre_mask;
  logic [HALF_W-1:0] half_cnt;
  logic              level, level_d, tmr_tick;

  assign pre_mask = ~({PC_W{1'b1}} << div_q);
  assign tmr_tick = tmr_en && ((pre_cnt & pre_mask) == pre_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q    <= DIV_W'(DIV_INIT);
      pre_cnt  <= '0;
      half_cnt <= '0;
      level    <= 1'b0;
      level_d  <= 1'b0;
    end else begin
      level_d <= level;
      if (div_wr) div_q <= div_val;
      if (tmr_en) pre_cnt <= pre_cnt + 1'b1;
      if (tmr_tick) begin
        if (half_cnt == HALF_W'(HALF - 1)) begin
          half_cnt <= '0;
          level    <= ~level;
        end else begin
          half_cnt <= half_cnt + 1'b1;
        end
      end
    end
  end

  assign tmr_out   = level & level_d;
  assign tmr_out_n = ~level & ~level_d;

  // ---------------- servo pulse ----------------
  logic [SET_W-1:0]   set_q, width_q;
  logic [UNIT_W-1:0]  unit_cnt;
  logic [FRAME_W-1:0] frame_cnt;
  logic               unit_tick, frame_last;

  assign unit_tick  = srv_en && (unit_cnt == UNIT_W'(UNIT_CLKS - 1));
  assign frame_last = (frame_cnt == FRAME_W'(FRAME_UNITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      set_q     <= SET_W'(SET_INIT);
      width_q   <= SET_W'(FIX_WIDTH);
      unit_cnt  <= '0;
      frame_cnt <= FRAME_W'(FRAME_UNITS - 1);
    end else begin
      if (set_wr) set_q <= set_val;
      if (srv_en) unit_cnt <= unit_tick ? '0 : unit_cnt + 1'b1;
      if (unit_tick) begin
        if (frame_last) begin
          frame_cnt <= '0;
          width_q   <= srv_val ? set_q : SET_W'(FIX_WIDTH);
        end else begin
          frame_cnt <= frame_cnt + 1'b1;
        end
      end
    end
  end

  assign srv_out = (frame_cnt < FRAME_W'(width_q));

  // ---------------- assertions ----------------
  a_r2_half_range: assert property (@(posedge clk) disable iff (!rst_n)
    half_cnt < HALF_W'(HALF));
  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(tmr_out && tmr_out_n));
  a_r3_dead_before_n: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_out_n) |-> $past(!tmr_out));
  a_r3_dead_before_p: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmr_out) |-> $past(!tmr_out_n));
  a_r5_timer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_en |=> $stable(half_cnt) && $stable(level));
  a_r6_frame_range: assert property (@(posedge clk) disable iff (!rst_n)
    frame_cnt < FRAME_W'(FRAME_UNITS));
  a_r9_width_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(width_q) |-> frame_cnt == '0);
  a_r10_servo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !srv_en |=> $stable(frame_cnt) && $stable(srv_out));

endmodule

// File: tb/timer_servo_pulse_bench.sv
module timer_servo_pulse_bench;
  localparam int UNIT = 4;
  localparam int WD   = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tmr_en = 0, div_wr = 0, srv_en = 0, srv_val = 0, set_wr = 0;
  logic [3:0] div_val = '0;
  logic [4:0] set_val = '0;
  logic tmr_out, tmr_out_n, srv_out;
  int checks = 0, failures = 0;
  bit timeout = 0;

  always #10 clk = ~clk;

  timer_servo_pulse #(.UNIT_CLKS(UNIT)) u_timer_servo_pulse (
    .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .div_wr(div_wr), .div_val(div_val),
    .srv_en(srv_en), .srv_val(srv_val), .set_wr(set_wr), .set_val(set_val),
    .tmr_out(tmr_out), .tmr_out_n(tmr_out_n), .srv_out(srv_out));

  function automatic logic sig(int s);
    return (s == 0) ? tmr_out : (s == 1) ? tmr_out_n : srv_out;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // waits for a fresh rising edge (0 then 1) and counts the high clocks
  task automatic high_len(int s, output int n);
    n = 0;
    do @(negedge clk); while (sig(s) != 1'b0);
    do @(negedge clk); while (sig(s) != 1'b1);
    while (sig(s) == 1'b1) begin n++; @(negedge clk); end
  endtask

  // from one rising edge to the next
  task automatic rise_gap(int s, output int n);
    do @(negedge clk); while (sig(s) != 1'b0);
    do @(negedge clk); while (sig(s) != 1'b1);
    n = 0;
    do begin @(negedge clk); n++; end while (sig(s) != 1'b0);
    do begin @(negedge clk); n++; end while (sig(s) != 1'b1);
  endtask

  task automatic write_div(int v);
    @(negedge clk); div_val = 4'(v); div_wr = 1;
    @(negedge clk); div_wr = 0;
  endtask

  task automatic write_set(int v);
    @(negedge clk); set_val = 5'(v); set_wr = 1;
    @(negedge clk); set_wr = 0;
  endtask

  task automatic t_reset;
    check(tmr_out == 0,   "R1 tmr_out", tmr_out, 0);
    check(tmr_out_n == 1, "R1 tmr_out_n", tmr_out_n, 1);
    check(srv_out == 0,   "R1 srv_out", srv_out, 0);
  endtask

  task automatic t_default_div;  // R4
    int seen = 0;
    @(negedge clk); tmr_en = 1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (tmr_out || !tmr_out_n) seen++;
    end
    check(seen == 0, "R4 default exponent holds timer", seen, 0);
  endtask

  task automatic t_timer(int n_exp);  // R2 R3
    int n, hi;
    write_div(n_exp);
    hi = 183 * (1 << n_exp) - 1;
    high_len(0, n);
    check(n == hi, "R2 tmr_out high clocks", n, hi);
    check(tmr_out_n == 0, "R3 dead clock after fall", tmr_out_n, 0);
    @(negedge clk);
    check(tmr_out_n == 1, "R3 complement rises after dead clock", tmr_out_n, 1);
    n = 0;
    while (tmr_out_n) begin n++; @(negedge clk); end
    check(n == hi, "R3 tmr_out_n high clocks", n, hi);
    check(tmr_out == 0, "R3 dead clock before rise", tmr_out, 0);
    rise_gap(0, n);
    check(n == 366 * (1 << n_exp), "R2 timer period", n, 366 * (1 << n_exp));
  endtask

  task automatic t_timer_hold;  // R5
    int bad = 0;
    do @(negedge clk); while (!tmr_out);
    repeat (10) @(negedge clk);
    tmr_en = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!tmr_out || tmr_out_n) bad++;
    end
    check(bad == 0, "R5 timer holds while disabled", bad, 0);
    tmr_en = 1;
  endtask

  task automatic t_servo_basic;  // R8 default, R6, R7
    int n;
    @(negedge clk); srv_val = 1; srv_en = 1;
    do @(negedge clk); while (!srv_out);
    n = 0;
    while (srv_out) begin n++; @(negedge clk); end
    check(n == 23 * UNIT, "R8 reset set count 23", n, 23 * UNIT);
    rise_gap(2, n);
    check(n == 235 * UNIT, "R6 servo frame", n, 235 * UNIT);
    srv_val = 0;
    high_len(2, n);
    check(n == 11 * UNIT, "R7 fixed width", n, 11 * UNIT);
  endtask

  task automatic t_servo_midframe;  // R9
    int n;
    do @(negedge clk); while (srv_out);
    do @(negedge clk); while (!srv_out);
    n = 0;
    for (int i = 0; i < 5; i++) begin n++; @(negedge clk); end
    srv_val = 1;
    while (srv_out) begin n++; @(negedge clk); end
    check(n == 11 * UNIT, "R9 value change mid pulse ignored", n, 11 * UNIT);
    high_len(2, n);
    check(n == 23 * UNIT, "R9 value change applies next frame", n, 23 * UNIT);
    do @(negedge clk); while (!srv_out);
    n = 1;
    @(negedge clk); set_val = 5'd30; set_wr = 1; n++;
    @(negedge clk); set_wr = 0;
    while (srv_out) begin n++; @(negedge clk); end
    check(n == 23 * UNIT, "R9 set write mid pulse ignored", n, 23 * UNIT);
    high_len(2, n);
    check(n == 30 * UNIT, "R9 set write applies next frame", n, 30 * UNIT);
  endtask

  task automatic t_servo_extremes;  // R8
    int n = 0;
    write_set(0);
    repeat (2 * 235 * UNIT) @(negedge clk);
    for (int i = 0; i < 235 * UNIT; i++) begin
      @(negedge clk);
      if (srv_out) n++;
    end
    check(n == 0, "R8 set count 0 gives no pulse", n, 0);
    write_set(31);
    do @(negedge clk); while (!srv_out);
    n = 0;
    while (srv_out) begin n++; @(negedge clk); end
    check(n == 31 * UNIT, "R8 set count 31", n, 31 * UNIT);
  endtask

  task automatic t_servo_hold;  // R10
    int bad = 0;
    do @(negedge clk); while (!srv_out);
    repeat (10) @(negedge clk);
    srv_en = 0;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!srv_out) bad++;
    end
    check(bad == 0, "R10 servo holds high while disabled", bad, 0);
    srv_en = 1;
    do @(negedge clk); while (srv_out);
    srv_en = 0;
    bad = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (srv_out) bad++;
    end
    check(bad == 0, "R10 servo holds low while disabled", bad, 0);
    srv_en = 1;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_default_div();
        t_timer(0);
        t_timer(2);
        t_timer_hold();
        t_servo_basic();
        t_servo_midframe();
        t_servo_extremes();
        t_servo_hold();
      end
      begin
        repeat (WD) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) check(1'b0, "watchdog", WD, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule